// File: doc/BRIEF.md
# Fractional Payload Mapper/Demapper

This block shares the payload bit positions of a DS3/E3 frame between two users, one bit at a time. The cell/packet processor gets a fraction of the positions. The rest form a low-rate side channel that is carried on an external serial port. In the transmit direction the block merges processor bits and side-channel bits into the outgoing payload. In the receive direction it splits the incoming payload the same way. Line positions that are not payload slots pass through unchanged.

Each direction decides, for every payload slot, whether that slot belongs to the processor or to the side channel. The decision comes from one of two sources, chosen by a mode input. The first is an internal repeating pattern of N processor slots followed by M side-channel slots, restarted by the frame pulse. The second is a per-slot allocation pin driven from outside. When side-channel slots go out on the transmit side, the bit sent is either a fixed fill pattern or data taken from the serial port.

All strobes and muxed data are combinational from the current slot inputs. The pattern counters and the alternating fill bit are registered.

Top module: `frac_map`

## Requirements
- R1: After reset, each direction's counter is at the first processor slot of its cycle, and the alternating fill bit is 1.
- R2: In counter mode (`ext_alloc_i`=0), payload slots repeat as `pay_len_i` processor slots followed by `ovh_len_i` side-channel slots. A length of 0 acts as 1.
- R3: A frame pulse restarts the cycle. A slot that arrives in the same cycle as the pulse is the first processor slot. A pulse without a slot leaves the cycle at its start.
- R4: In external mode (`ext_alloc_i`=1), a slot with its direction's allocation pin at 1 is a processor slot, and a slot with the pin at 0 is a side-channel slot.
- R5: On a transmit processor slot, `tx_pay_req_o`=1 and `tx_bit_o`=`tx_pay_dat_i`. On a transmit side-channel slot, `tx_ovh_en_o`=1 and `tx_bit_o` is the selected fill bit. Exactly one of the two strobes is high on each slot.
- R6: `ovh_src_i` selects the transmit fill: 0 sends zeros, 1 sends ones, 2 sends the alternating bit, and 3 sends `tx_ovh_dat_i`.
- R7: The alternating bit toggles after each transmit side-channel slot. Processor slots and idle cycles leave it unchanged.
- R8: On a receive processor slot, `rx_pay_vld_o`=1 and `rx_pay_dat_o`=`rx_bit_i`. On a receive side-channel slot, `rx_ovh_en_o`=1 and `rx_ovh_dat_o`=`rx_bit_i`. A data output is 0 while its strobe is low.
- R9: When the slot strobe is low, no strobe is raised, `tx_bit_o`=`tx_bit_i`, and the counter position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_alloc_i | input | 1 | 1 selects the allocation pins, 0 selects the internal counters |
| pay_len_i | input | CNT_W | Processor slots per cycle |
| ovh_len_i | input | CNT_W | Side-channel slots per cycle |
| ovh_src_i | input | 2 | Transmit fill select |
| tx_frame_i | input | 1 | Transmit frame start pulse |
| tx_slot_i | input | 1 | Transmit payload slot strobe |
| tx_alloc_i | input | 1 | Transmit external allocation |
| tx_bit_i | input | 1 | Framer transmit bit, passed through on non-slot positions |
| tx_pay_req_o | output | 1 | Processor data request |
| tx_pay_dat_i | input | 1 | Processor transmit bit |
| tx_ovh_en_o | output | 1 | Serial side-channel transmit clock enable |
| tx_ovh_dat_i | input | 1 | Serial side-channel transmit bit |
| tx_bit_o | output | 1 | Transmit line bit to the framer |
| rx_frame_i | input | 1 | Receive frame start pulse |
| rx_slot_i | input | 1 | Receive payload slot strobe |
| rx_alloc_i | input | 1 | Receive external allocation |
| rx_bit_i | input | 1 | Received line bit |
| rx_pay_vld_o | output | 1 | Processor data valid |
| rx_pay_dat_o | output | 1 | Processor receive bit |
| rx_ovh_en_o | output | 1 | Serial side-channel receive clock enable |
| rx_ovh_dat_o | output | 1 | Serial side-channel receive bit |

## Verification
A frame pulse can arrive in the same cycle as a payload slot. The restart and the slot's own counter advance then happen together. The bench raises the pulse together with a slot partway through a counter cycle, and also raises a pulse with no slot. It then checks that the colliding slot is a processor slot and that the positions that follow continue from the new cycle start. Payload slots and idle cycles are also interleaved with side-channel slots under the alternating fill, to show that only side-channel slots move the alternating bit.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [1:0] {
    OVH_ZERO = 2'd0,
    OVH_ONE  = 2'd1,
    OVH_ALT  = 2'd2,
    OVH_EXT  = 2'd3
  } ovh_src_e;
endpackage

// File: rtl/frac_alloc.sv
module frac_alloc #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic [CNT_W-1:0] pay_len_i,
  input  logic [CNT_W-1:0] ovh_len_i,
  input  logic             frame_i,
  input  logic             slot_i,
  input  logic             alloc_i,
  output logic             is_pay_o
);
  logic             in_ovh_q, in_ovh_d, eff_ovh;
  logic [CNT_W-1:0] cnt_q, cnt_d, eff_cnt, lim, pay_lim, ovh_lim;

  assign pay_lim = (pay_len_i == '0) ? CNT_W'(1) : pay_len_i;
  assign ovh_lim = (ovh_len_i == '0) ? CNT_W'(1) : ovh_len_i;

  always_comb begin
    eff_ovh  = frame_i ? 1'b0 : in_ovh_q;
    eff_cnt  = frame_i ? '0 : cnt_q;
    lim      = eff_ovh ? ovh_lim : pay_lim;
    in_ovh_d = eff_ovh;
    cnt_d    = eff_cnt;
    if (slot_i) begin
      // >= keeps a shortened length from running away mid-cycle
      if (eff_cnt >= lim - CNT_W'(1)) begin
        in_ovh_d = ~eff_ovh;
        cnt_d    = '0;
      end else begin
        cnt_d = eff_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_ovh_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      in_ovh_q <= in_ovh_d;
      cnt_q    <= cnt_d;
    end
  end

  assign is_pay_o = ext_mode_i ? alloc_i : ~eff_ovh;

  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !slot_i) |=> (!in_ovh_q && cnt_q == '0)); // R3
  AST_FRAME_SLOT_PAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && slot_i && !ext_mode_i) |-> is_pay_o); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_i && !frame_i) |=> ($stable(in_ovh_q) && $stable(cnt_q))); // R9
endmodule

// File: rtl/frac_ovh_src.sv
module frac_ovh_src
  import frac_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ovh_src_e src_i,
  input  logic     adv_i,
  input  logic     ext_dat_i,
  output logic     bit_o
);
  logic alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    alt_q <= 1'b1;
    else if (adv_i) alt_q <= ~alt_q;
  end

  always_comb begin
    unique case (src_i)
      OVH_ZERO: bit_o = 1'b0;
      OVH_ONE:  bit_o = 1'b1;
      OVH_ALT:  bit_o = alt_q;
      default:  bit_o = ext_dat_i;
    endcase
  end

  AST_ALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(alt_q)); // R7
  AST_ALT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (alt_q != $past(alt_q))); // R7
endmodule

// File: rtl/frac_map.sv
module frac_map
  import frac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_alloc_i,
  input  logic [CNT_W-1:0] pay_len_i,
  input  logic [CNT_W-1:0] ovh_len_i,
  input  logic [1:0]       ovh_src_i,
  input  logic             tx_frame_i,
  input  logic             tx_slot_i,
  input  logic             tx_alloc_i,
  input  logic             tx_bit_i,
  output logic             tx_pay_req_o,
  input  logic             tx_pay_dat_i,
  output logic             tx_ovh_en_o,
  input  logic             tx_ovh_dat_i,
  output logic             tx_bit_o,
  input  logic             rx_frame_i,
  input  logic             rx_slot_i,
  input  logic             rx_alloc_i,
  input  logic             rx_bit_i,
  output logic             rx_pay_vld_o,
  output logic             rx_pay_dat_o,
  output logic             rx_ovh_en_o,
  output logic             rx_ovh_dat_o
);
  logic tx_is_pay, rx_is_pay, fill_bit;

  frac_alloc #(.CNT_W(CNT_W)) u_tx_alloc (
    .clk_i, .rst_ni, .ext_mode_i(ext_alloc_i), .pay_len_i, .ovh_len_i,
    .frame_i(tx_frame_i), .slot_i(tx_slot_i), .alloc_i(tx_alloc_i),
    .is_pay_o(tx_is_pay)
  );

  frac_alloc #(.CNT_W(CNT_W)) u_rx_alloc (
    .clk_i, .rst_ni, .ext_mode_i(ext_alloc_i), .pay_len_i, .ovh_len_i,
    .frame_i(rx_frame_i), .slot_i(rx_slot_i), .alloc_i(rx_alloc_i),
    .is_pay_o(rx_is_pay)
  );

  frac_ovh_src u_fill (
    .clk_i, .rst_ni, .src_i(ovh_src_e'(ovh_src_i)), .adv_i(tx_ovh_en_o),
    .ext_dat_i(tx_ovh_dat_i), .bit_o(fill_bit)
  );

  assign tx_pay_req_o = tx_slot_i & tx_is_pay;
  assign tx_ovh_en_o  = tx_slot_i & ~tx_is_pay;
  always_comb begin
    if (tx_pay_req_o)     tx_bit_o = tx_pay_dat_i;
    else if (tx_ovh_en_o) tx_bit_o = fill_bit;
    else                  tx_bit_o = tx_bit_i;
  end

  assign rx_pay_vld_o = rx_slot_i & rx_is_pay;
  assign rx_ovh_en_o  = rx_slot_i & ~rx_is_pay;
  assign rx_pay_dat_o = rx_pay_vld_o & rx_bit_i;
  assign rx_ovh_dat_o = rx_ovh_en_o & rx_bit_i;

  AST_TX_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_slot_i |-> ($countones({tx_pay_req_o, tx_ovh_en_o}) == 1)); // R5
  AST_RX_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_slot_i |-> ($countones({rx_pay_vld_o, rx_ovh_en_o}) == 1)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_slot_i && !rx_slot_i) |-> !(tx_pay_req_o || tx_ovh_en_o || rx_pay_vld_o || rx_ovh_en_o)); // R9
  AST_RX_DAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_pay_vld_o |-> !rx_pay_dat_o); // R8
endmodule

// File: tb/frac_map_bench.sv
`timescale 1ns/1ps
module frac_map_bench;
  logic       clk = 0, rst_n = 0;
  logic       ext = 0;
  logic [7:0] pay_len = 8'd3, ovh_len = 8'd2;
  logic [1:0] src = 2'd1;
  logic tx_fr = 0, tx_sl = 0, tx_al = 0, tx_b = 0, tx_pd = 0, tx_od = 0;
  logic rx_fr = 0, rx_sl = 0, rx_al = 0, rx_b = 0;
  logic tx_req, tx_oen, tx_bo, rx_vld, rx_pd, rx_oen, rx_od;
  int   checks = 0, errors = 0;

  always #5 clk = ~clk;

  frac_map u_frac_map (
    .clk_i(clk), .rst_ni(rst_n), .ext_alloc_i(ext), .pay_len_i(pay_len),
    .ovh_len_i(ovh_len), .ovh_src_i(src),
    .tx_frame_i(tx_fr), .tx_slot_i(tx_sl), .tx_alloc_i(tx_al), .tx_bit_i(tx_b),
    .tx_pay_req_o(tx_req), .tx_pay_dat_i(tx_pd), .tx_ovh_en_o(tx_oen),
    .tx_ovh_dat_i(tx_od), .tx_bit_o(tx_bo),
    .rx_frame_i(rx_fr), .rx_slot_i(rx_sl), .rx_alloc_i(rx_al), .rx_bit_i(rx_b),
    .rx_pay_vld_o(rx_vld), .rx_pay_dat_o(rx_pd), .rx_ovh_en_o(rx_oen),
    .rx_ovh_dat_o(rx_od)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tx_sl = 0; tx_fr = 0; rx_sl = 0; rx_fr = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one transmit slot, checked mid-cycle, inputs changed at negedge
  task automatic tx_slot(input bit fr, input bit al, input bit exp_pay,
                         input bit pd, input bit exp_fill, input string rq);
    tx_fr = fr; tx_sl = 1; tx_al = al; tx_pd = pd; tx_b = ~pd;
    #2;
    chk(tx_req == exp_pay, {rq, " req"}, tx_req, exp_pay);
    chk(tx_oen == !exp_pay, {rq, " ovh_en"}, tx_oen, !exp_pay);
    chk(tx_bo == (exp_pay ? pd : exp_fill), {rq, " bit"}, tx_bo, exp_pay ? pd : exp_fill);
    @(negedge clk);
    tx_fr = 0; tx_sl = 0;
  endtask

  task automatic tx_idle(input bit fr, input bit b, input string rq);
    tx_fr = fr; tx_sl = 0; tx_b = b;
    #2;
    chk(tx_bo == b, {rq, " pass"}, tx_bo, b);
    chk(!tx_req && !tx_oen, {rq, " quiet"}, {tx_req, tx_oen}, 0);
    @(negedge clk);
    tx_fr = 0;
  endtask

  task automatic rx_slot(input bit fr, input bit al, input bit exp_pay,
                         input bit b, input string rq);
    rx_fr = fr; rx_sl = 1; rx_al = al; rx_b = b;
    #2;
    chk(rx_vld == exp_pay, {rq, " vld"}, rx_vld, exp_pay);
    chk(rx_oen == !exp_pay, {rq, " ovh_en"}, rx_oen, !exp_pay);
    chk(rx_pd == (exp_pay & b), {rq, " pay dat"}, rx_pd, exp_pay & b);
    chk(rx_od == (!exp_pay & b), {rq, " ovh dat"}, rx_od, !exp_pay & b);
    @(negedge clk);
    rx_fr = 0; rx_sl = 0;
  endtask

  task automatic t_reset();
    ext = 0; pay_len = 8'd2; ovh_len = 8'd2; src = 2'd2;
    do_reset();
    tx_idle(0, 1, "R9 after reset");
    tx_slot(0, 0, 1, 0, 0, "R1 first slot payload");
    tx_slot(0, 0, 1, 1, 0, "R1 second slot payload");
    tx_slot(0, 0, 0, 0, 1, "R1 alt starts at 1");
  endtask

  task automatic t_counter();
    int pos = 0;
    ext = 0; pay_len = 8'd3; ovh_len = 8'd2; src = 2'd1;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      tx_slot(0, 0, pos < 3, i[0], 1, "R2 count pattern");
      pos = (pos + 1) % 5;
      if (i % 3 == 2) tx_idle(0, i[1], "R9 gap");
    end
  endtask

  task automatic t_frame();
    ext = 0; pay_len = 8'd3; ovh_len = 8'd2; src = 2'd0;
    do_reset();
    for (int i = 0; i < 4; i++) tx_slot(0, 0, i < 3, 1, 0, "R2 pre-frame");
    tx_slot(1, 0, 1, 1, 0, "R3 frame with slot");
    tx_slot(0, 0, 1, 0, 0, "R3 after frame 1");
    tx_slot(0, 0, 1, 1, 0, "R3 after frame 2");
    tx_slot(0, 0, 0, 1, 0, "R3 after frame 3");
    tx_idle(1, 0, "R3 bare frame");
    tx_slot(0, 0, 1, 1, 0, "R3 bare frame restart");
  endtask

  task automatic t_zero_len();
    ext = 0; pay_len = 8'd0; ovh_len = 8'd0; src = 2'd1;
    do_reset();
    for (int i = 0; i < 6; i++) tx_slot(0, 0, i % 2 == 0, 0, 1, "R2 zero length as one");
  endtask

  task automatic t_external();
    ext = 1; pay_len = 8'd1; ovh_len = 8'd1; src = 2'd1;
    do_reset();
    tx_slot(0, 1, 1, 0, 1, "R4 tx pin high");
    tx_slot(0, 1, 1, 1, 1, "R4 tx pin high again");
    tx_slot(0, 0, 0, 0, 1, "R4 tx pin low");
    tx_slot(1, 0, 0, 0, 1, "R4 frame ignored");
    rx_slot(0, 0, 0, 1, "R4 rx pin low");
    rx_slot(0, 1, 1, 1, "R4 rx pin high");
  endtask

  task automatic t_sources();
    ext = 1;
    do_reset();
    src = 2'd0; tx_od = 1;
    tx_slot(0, 0, 0, 1, 0, "R6 zeros");
    src = 2'd1; tx_od = 0;
    tx_slot(0, 0, 0, 0, 1, "R6 ones");
    src = 2'd3; tx_od = 1;
    tx_slot(0, 0, 0, 0, 1, "R6 external 1");
    tx_od = 0;
    tx_slot(0, 0, 0, 1, 0, "R6 external 0");
    tx_slot(0, 1, 1, 1, 0, "R5 payload data 1");
    tx_slot(0, 1, 1, 0, 0, "R5 payload data 0");
  endtask

  task automatic t_alt();
    ext = 1; src = 2'd2;
    do_reset();
    tx_slot(0, 0, 0, 0, 1, "R7 alt 1");
    tx_slot(0, 1, 1, 0, 0, "R7 payload slot");
    tx_slot(0, 0, 0, 1, 0, "R7 alt 0 after payload");
    tx_idle(0, 1, "R7 idle");
    tx_slot(0, 0, 0, 0, 1, "R7 alt 1 after idle");
    tx_slot(0, 0, 0, 0, 0, "R7 alt 0");
  endtask

  task automatic t_rx();
    ext = 0; pay_len = 8'd2; ovh_len = 8'd3;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      rx_slot(0, 0, (i % 5) < 2, i[0] ^ i[2], "R8 rx split");
      if (i == 4) begin
        rx_sl = 0; rx_b = 1; #2;
        chk(!rx_vld && !rx_oen, "R9 rx idle quiet", {rx_vld, rx_oen}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    t_reset();
    t_counter();
    t_frame();
    t_zero_len();
    t_external();
    t_sources();
    t_alt();
    t_rx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule